// File: doc/BRIEF.md
# Edge-Triggered Delayed One-Shot Pulse Generator

This block produces a single output pulse some time after an input event. It watches one line picked from a small bank of trigger inputs and waits for the chosen polarity of transition on it. Once an edge is accepted, the block counts a programmable number of timer ticks as a delay. It then raises the pulse output and holds it for a programmable number of further ticks. Ticks come from a one-clock-wide tick-enable input, so a prescaler elsewhere sets the time base. Edges are detected at the full clock rate.

The block moves through four phases and shows the current one on a 2-bit code. The phases are waiting, counting the delay, shot started and shot active. The started phase always lasts exactly one tick. It marks the tick on which the output first goes high. When the active phase ends, the block returns to waiting and raises a done strobe for one clock. Software or a neighbouring block can read the phase code to follow the shot. The delay and width operands are captured when the edge is accepted. Dropping the enable input abandons any shot in progress.

Top module: `delayed_oneshot`

## Requirements
- R1: While reset is asserted and on the first clock after it, the phase code is 0, the pulse is low and done is low.
- R2: The phase code is 0 = waiting, 1 = delay, 2 = started, 3 = active. The pulse output is high exactly in phases 2 and 3.
- R3: The trigger is input `trig_i[src_sel_i]`. A rising edge is accepted when `fall_sel_i` is 0, and a falling edge when it is 1. Edges of the opposite polarity are ignored, and so are edges on any other input.
- R4: An accepted edge leaves the phase at 0 until the next tick. On that tick the block goes to phase 2 if the captured delay is 0, and otherwise to phase 1. Phase 1 lasts exactly `delay` ticks. With a tick on every clock, the pulse is seen high delay+2 clocks after the edge is applied.
- R5: Phase 2 lasts exactly one tick.
- R6: Phase 3 lasts exactly `width` ticks, so the pulse is high for width+1 ticks. A width of 0 returns the block from phase 2 straight to phase 0.
- R7: On the clock after the tick that ends the pulse, done is high for exactly one clock and the phase is 0.
- R8: Edges that arrive after an edge has been accepted are ignored until the block is back in phase 0. This covers the pending wait for the first tick and phases 1 to 3. One event therefore yields one pulse.
- R9: While `en_i` is low, the next clock forces phase 0 with the pulse and done low. Any pending edge is dropped, and edges during that time are ignored.
- R10: The delay and width are sampled when the edge is accepted. Changing `delay_i` or `width_i` later does not alter the shot in progress.
- R11: A clock without a tick never changes the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Block enable; low returns to waiting |
| tick_i | input | 1 | Timer tick enable, one clock wide |
| trig_i | input | N_SRC | Bank of candidate trigger lines |
| src_sel_i | input | SEL_W | Index of the trigger line to watch |
| fall_sel_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| delay_i | input | CNT_W | Delay in ticks from event to pulse start |
| width_i | input | CNT_W | Extra ticks of pulse after the started tick |
| pulse_o | output | 1 | Shot output |
| phase_o | output | 2 | Current phase code |
| done_o | output | 1 | One-clock strobe when a shot completes |

## Verification
Every result here is registered, so a phase change caused by a tick is visible on the clock after that tick. The done strobe appears on the clock after the tick that ends the pulse. With a tick on every clock, an edge applied in one cycle shows the pulse delay+2 clocks later, and the pulse stays high for width+1 clocks. The bench drives inputs just after the falling clock edge. It compares the outputs one full cycle later, at the next falling edge, against a cycle model stepped on each rising edge. Directed shots count clocks from the edge to pulse start and pulse end. Those counts are checked against the delay+2 and width+1 figures, with ticks held continuous or paused to test stalls.

// File: rtl/dos_pkg.sv
package dos_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_FIRE  = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;
endpackage

// File: rtl/dos_edge_sel.sv
module dos_edge_sel #(
   parameter int N_SRC       = 4,
   parameter int SYNC_STAGES = 0,
   localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             fall_i,
   output logic             edge_o
);
   logic [N_SRC-1:0] src_s;
   logic             cur;
   logic             prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign src_s = src_i;
      end else begin : g_sync
         logic [N_SRC-1:0] sh_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) sh_q[i] <= '0;
            end else begin
               sh_q[0] <= src_i;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign src_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign cur = (int'(sel_i) < N_SRC) ? src_s[sel_i] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign edge_o = fall_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/dos_down_cnt.sv
module dos_down_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o,
   output logic             one_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
   assign one_o  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/delayed_oneshot.sv
module delayed_oneshot
   import dos_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_SRC       = 4,
   parameter int SYNC_STAGES = 0,
   localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [N_SRC-1:0] trig_i,
   input  logic [SEL_W-1:0] src_sel_i,
   input  logic             fall_sel_i,
   input  logic [CNT_W-1:0] delay_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             pulse_o,
   output logic [1:0]       phase_o,
   output logic             done_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (N_SRC < 1) begin : g_bad_src
         $error("N_SRC must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   phase_e           phase_q, phase_n;
   logic             pend_q, pend_n;
   logic [CNT_W-1:0] wid_q, wid_n;
   logic             done_q, done_n;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             dec;
   logic             cnt_zero, cnt_one;
   logic             evt;

   dos_edge_sel #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (trig_i),
      .sel_i  (src_sel_i),
      .fall_i (fall_sel_i),
      .edge_o (evt)
   );

   dos_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (ld_val),
      .dec_i      (dec),
      .zero_o     (cnt_zero),
      .one_o      (cnt_one)
   );

   always_comb begin
      phase_n = phase_q;
      pend_n  = pend_q;
      wid_n   = wid_q;
      done_n  = 1'b0;
      ld      = 1'b0;
      ld_val  = '0;
      dec     = 1'b0;
      if (!en_i) begin
         phase_n = PH_IDLE;
         pend_n  = 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (!pend_q && evt) begin
                  pend_n = 1'b1;
                  ld     = 1'b1;
                  ld_val = delay_i;
                  wid_n  = width_i;
               end else if (pend_q && tick_i) begin
                  pend_n  = 1'b0;
                  phase_n = cnt_zero ? PH_FIRE : PH_DELAY;
               end
            end
            PH_DELAY: begin
               if (tick_i) begin
                  if (cnt_one) phase_n = PH_FIRE;
                  else         dec     = 1'b1;
               end
            end
            PH_FIRE: begin
               if (tick_i) begin
                  if (wid_q == '0) begin
                     phase_n = PH_IDLE;
                     done_n  = 1'b1;
                  end else begin
                     phase_n = PH_HOLD;
                     ld      = 1'b1;
                     ld_val  = wid_q;
                  end
               end
            end
            PH_HOLD: begin
               if (tick_i) begin
                  if (cnt_one) begin
                     phase_n = PH_IDLE;
                     done_n  = 1'b1;
                  end else begin
                     dec = 1'b1;
                  end
               end
            end
            default: phase_n = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pend_q  <= 1'b0;
         wid_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_n;
         pend_q  <= pend_n;
         wid_q   <= wid_n;
         done_q  <= done_n;
      end
   end

   assign phase_o = phase_q;
   assign pulse_o = phase_q[1];
   assign done_o  = done_q;
endmodule

// File: rtl/dos_chk.sv
module dos_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       tick,
   input logic [1:0] phase,
   input logic       pulse,
   input logic       done
);
   // R5: the started phase is left on its single tick
   a_r5_fire_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && phase == 2'd2) |=> (phase != 2'd2));

   // R11: no tick, no phase change
   a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(phase));

   // R7: done comes with phase 0 right after a high pulse
   a_r7_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase == 2'd0 && $past(pulse)));

   // R7: done lasts one clock
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: disable forces waiting with output low
   a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == 2'd0 && !pulse && !done));

   // R2: the delay phase leads only to itself or the started phase
   a_r2_delay_next: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == 2'd1) |=> (phase == 2'd1 || phase == 2'd2));

   // R6: the active phase leads only to itself or waiting
   a_r6_hold_next: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == 2'd3) |=> (phase == 2'd3 || phase == 2'd0));
endmodule

bind delayed_oneshot dos_chk u_dos_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en_i),
   .tick  (tick_i),
   .phase (phase_o),
   .pulse (pulse_o),
   .done  (done_o)
);

// File: tb/delayed_oneshot_bench.sv
module delayed_oneshot_bench;
   localparam int CLK_P = 10;
   localparam int CW    = 16;
   localparam int NS    = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en_i, tick_i, fall_sel_i;
   logic [NS-1:0] trig_i;
   logic [1:0]    src_sel_i;
   logic [CW-1:0] delay_i, width_i;
   logic          pulse_o, done_o;
   logic [1:0]    phase_o;

   int checks = 0;
   int errors = 0;

   delayed_oneshot #(.CNT_W(CW), .N_SRC(NS)) u_delayed_oneshot (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .trig_i(trig_i),
      .src_sel_i(src_sel_i), .fall_sel_i(fall_sel_i), .delay_i(delay_i),
      .width_i(width_i), .pulse_o(pulse_o), .phase_o(phase_o), .done_o(done_o)
   );

   always #(CLK_P/2) clk = ~clk;

   // cycle model built from the requirements
   int m_phase, m_left, m_wid;
   bit m_pend, m_done, m_prev;
   always @(posedge clk) begin
      bit cur, e;
      cur = trig_i[src_sel_i];
      e   = fall_sel_i ? (!cur && m_prev) : (cur && !m_prev);
      if (!rst_n) begin
         m_phase = 0; m_pend = 0; m_done = 0; m_left = 0; m_wid = 0; m_prev = 0;
      end else begin
         m_done = 0;
         if (!en_i) begin
            m_phase = 0; m_pend = 0;
         end else begin
            case (m_phase)
               0: if (!m_pend && e) begin
                     m_pend = 1; m_left = int'(delay_i); m_wid = int'(width_i);
                  end else if (m_pend && tick_i) begin
                     m_pend = 0; m_phase = (m_left == 0) ? 2 : 1;
                  end
               1: if (tick_i) begin
                     if (m_left == 1) m_phase = 2; else m_left--;
                  end
               2: if (tick_i) begin
                     if (m_wid == 0) begin m_phase = 0; m_done = 1; end
                     else begin m_phase = 3; m_left = m_wid; end
                  end
               default: if (tick_i) begin
                     if (m_left == 1) begin m_phase = 0; m_done = 1; end
                     else m_left--;
                  end
            endcase
         end
         m_prev = cur;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tickc();
      @(negedge clk);
      chk("R2 phase code", int'(phase_o), m_phase);
      chk("R2 pulse level", int'(pulse_o), (m_phase >= 2) ? 1 : 0);
      chk("R7 done strobe", int'(done_o), int'(m_done));
   endtask

   // park the selected line at its idle level with the block disabled
   task automatic park(input bit fall);
      en_i = 1'b0;
      trig_i[src_sel_i] = fall;
      fall_sel_i = fall;
      tickc(); tickc();
      en_i = 1'b1;
      tickc();
   endtask

   task automatic shot(input int d, input int w, input bit fall, input bit alter,
                       output int ts, output int fs, output int hl, output int dn,
                       output bit sawd);
      delay_i = CW'(d); width_i = CW'(w);
      park(fall);
      trig_i[src_sel_i] = ~fall;
      ts = 0; sawd = 0; fs = 0; hl = 0; dn = 0;
      while (!pulse_o && ts < 200) begin
         tickc(); ts++;
         if (alter && ts == 1) begin delay_i = CW'(9); width_i = CW'(9); end
         if (phase_o == 2'd1) sawd = 1;
      end
      while (pulse_o && hl < 300) begin
         hl++;
         if (phase_o == 2'd2) fs++;
         tickc();
         if (done_o) dn++;
      end
      tickc();
      if (done_o) dn++;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int ts, fs, hl, dn, cnt;
      bit sawd;
      void'($urandom(32'd2024));
      rst_n = 1'b0; en_i = 1'b1; tick_i = 1'b1; trig_i = '0; src_sel_i = 2'd1;
      fall_sel_i = 1'b0; delay_i = '0; width_i = '0;
      repeat (3) begin
         tickc();
         chk("R1 reset phase", int'(phase_o), 0);
         chk("R1 reset pulse", int'(pulse_o), 0);
      end
      rst_n = 1'b1;
      tickc();
      chk("R1 after reset phase", int'(phase_o), 0);

      // R4 R5 R6 R7: nominal shot
      shot(3, 2, 0, 0, ts, fs, hl, dn, sawd);
      chk("R4 edge to pulse clocks", ts, 5);
      chk("R4 delay phase seen", int'(sawd), 1);
      chk("R5 started phase clocks", fs, 1);
      chk("R6 pulse clocks", hl, 3);
      chk("R7 done count", dn, 1);

      // R4: zero delay skips the delay phase
      shot(0, 4, 0, 0, ts, fs, hl, dn, sawd);
      chk("R4 zero delay clocks", ts, 2);
      chk("R4 zero delay no phase 1", int'(sawd), 0);
      chk("R6 width 4 pulse clocks", hl, 5);

      // R3 falling edge with R6 zero width
      shot(2, 0, 1, 0, ts, fs, hl, dn, sawd);
      chk("R3 falling edge start", ts, 4);
      chk("R6 zero width pulse clocks", hl, 1);
      chk("R7 zero width done", dn, 1);

      // R10: operands changed after acceptance
      shot(3, 2, 0, 1, ts, fs, hl, dn, sawd);
      chk("R10 delay kept", ts, 5);
      chk("R10 width kept", hl, 3);

      // R3: wrong polarity ignored
      park(1'b1);
      fall_sel_i = 1'b0;
      tickc();
      trig_i[src_sel_i] = 1'b0;
      cnt = 0;
      repeat (10) begin tickc(); if (phase_o != 2'd0) cnt++; end
      chk("R3 opposite edge ignored", cnt, 0);

      // R3: unselected input ignored
      trig_i[0] = 1'b1; trig_i[2] = 1'b1;
      cnt = 0;
      repeat (10) begin tickc(); if (phase_o != 2'd0) cnt++; end
      chk("R3 other input ignored", cnt, 0);
      trig_i = '0;
      tickc();

      // R8: edges during pending, delay and active ignored
      delay_i = CW'(4); width_i = CW'(6);
      park(1'b0);
      trig_i[src_sel_i] = 1'b1;
      cnt = 0;
      for (int i = 0; i < 48; i++) begin
         bit was;
         was = pulse_o;
         tickc();
         if (pulse_o && !was) cnt++;
         if (i < 8) trig_i[src_sel_i] = ~trig_i[src_sel_i];
         else       trig_i[src_sel_i] = 1'b0;
      end
      chk("R8 one pulse per event", cnt, 1);

      // R9: disable mid-shot
      delay_i = CW'(1); width_i = CW'(8);
      park(1'b0);
      trig_i[src_sel_i] = 1'b1;
      repeat (5) tickc();
      chk("R9 pulse before disable", int'(pulse_o), 1);
      en_i = 1'b0;
      tickc();
      chk("R9 phase after disable", int'(phase_o), 0);
      chk("R9 pulse after disable", int'(pulse_o), 0);
      trig_i[src_sel_i] = 1'b0; tickc();
      trig_i[src_sel_i] = 1'b1; tickc();
      en_i = 1'b1;
      cnt = 0;
      repeat (10) begin tickc(); if (phase_o != 2'd0) cnt++; end
      chk("R9 edges while disabled ignored", cnt, 0);

      // R11: stalled ticks
      delay_i = CW'(2); width_i = CW'(1);
      park(1'b0);
      tick_i = 1'b0;
      trig_i[src_sel_i] = 1'b1;
      cnt = 0;
      repeat (6) begin tickc(); if (phase_o != 2'd0) cnt++; end
      chk("R11 pending holds without tick", cnt, 0);
      tick_i = 1'b1; tickc(); tick_i = 1'b0;
      tickc();
      chk("R11 delay entered", int'(phase_o), 1);
      cnt = 0;
      repeat (8) begin tickc(); if (phase_o != 2'd1) cnt++; end
      chk("R11 delay holds without tick", cnt, 0);
      tick_i = 1'b1;
      repeat (10) tickc();

      // random traffic against the model (R2 R7 per cycle)
      for (int i = 0; i < 4000; i++) begin
         tickc();
         tick_i = ($urandom % 3) != 0;
         if (($urandom % 5) == 0) trig_i[$urandom % NS] = $urandom % 2;
         en_i = ($urandom % 150) != 0;
         if (($urandom % 300) == 0) fall_sel_i = $urandom % 2;
         if (($urandom % 400) == 0) src_sel_i = 2'($urandom % NS);
         delay_i = CW'($urandom % 6);
         width_i = CW'($urandom % 6);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule